// File: doc/BRIEF.md
# Line Interface Loopback Controller

This block sits between the system side and the line side of a serial line interface and decides where each bit stream goes. In normal operation, bits from the system go out on the line and bits recovered from the line go up to the system. On request it turns the line stream back towards the line (remote loopback), turns the system stream back towards the system (local loopback), or does both at once (dual loopback). Each stream is a data symbol qualified by a one-cycle strobe that marks the start of a new bit.

Requests come from one of two control sources, picked by a select input. The first is a set of host register bits: remote, local and network-detect enable. The second is a pair of hardware pins. The remote pin is three-level and arrives encoded on two wires: low means no request, mid enables network-loopback detection, and high requests remote loopback. An external pattern detector raises a flag once the network-loopback enable pattern has been qualified. When detection is enabled, that flag activates a network loopback, which routes the streams exactly as remote loopback does. A new mode takes effect only on a cycle that carries a line-receive strobe, so no output bit is cut short. A status output reports the mode in force.

Top module: `lbk_ctrl`

## Requirements
- R1: While reset is asserted, both output strobes and both output data lines are 0 and the mode status reads normal (code 0).
- R2: In normal mode (status 0), the line transmit output carries the system transmit data and strobe, and the system receive output carries the line receive data and strobe. Each output lags its source by one clock.
- R3: In remote mode (status 1), the line transmit output carries the line receive data and strobe. System transmit strobes and data have no effect on the line transmit output. The system receive output still carries the line receive stream.
- R4: In local mode (status 2), the system receive output carries the system transmit data and strobe, and the line transmit output still carries the system transmit stream.
- R5: Network mode (status 3) is entered when detection is enabled, the detector flag is high and no remote request is present. A remote request takes precedence over network loopback. Routing in network mode is identical to remote mode.
- R6: Dual mode (status 4) results from remote plus local requests, or from an active network loopback plus a local request. The line transmit output then carries the line receive stream and the system receive output carries the system transmit stream.
- R7: With hardware control selected (select = 1), the remote pin code decides the request: 2'b10 requests remote, 2'b01 enables network detection, and 2'b00 or 2'b11 requests nothing. The local pin requests local loopback. Host bits are ignored.
- R8: With host control selected (select = 0), the pins are ignored and the three host bits give the remote request, the local request and the detection enable.
- R9: The mode status, and the routing that goes with it, changes only on the clock edge following a cycle in which the line receive strobe is high. Between such cycles, request changes do not alter the status or routing.
- R10: Each output data line changes only in the cycle in which its own output strobe is high. Between strobes it holds the last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_use_pins | input | 1 | 1 selects hardware pins, 0 selects host bits |
| host_rmt_req | input | 1 | Host remote-loopback request bit |
| host_loc_req | input | 1 | Host local-loopback request bit |
| host_net_det_en | input | 1 | Host network-detection enable bit |
| pin_rmt_lvl | input | 2 | Remote pin level: 00 low, 01 mid, 10 high, 11 low |
| pin_loc_req | input | 1 | Local-loopback pin |
| net_pat_seen | input | 1 | Detector flag: network loopback enable pattern qualified |
| sys_tx_data | input | DW | System transmit data |
| sys_tx_stb | input | 1 | System transmit bit strobe |
| line_rx_data | input | DW | Line receive data |
| line_rx_stb | input | 1 | Line receive bit strobe |
| line_tx_data | output | DW | Line transmit data |
| line_tx_stb | output | 1 | Line transmit bit strobe |
| sys_rx_data | output | DW | System receive data |
| sys_rx_stb | output | 1 | System receive bit strobe |
| mode_stat | output | 3 | Mode in force: 0 normal, 1 remote, 2 local, 3 network, 4 dual |

## Verification
The routing is first tried with both strobes high on every cycle, while the two data inputs carry opposite values. Each output bit then shows which source fed it, and every combination of host bits, pin codes (including the unused 11 code) and detector flag can be mapped to one mode and one routing. Cases where a remote request and an active network loopback coexist, or where the unselected control source is fully asserted, show whether precedence and source selection are handled correctly. Directed sequences then raise one strobe at a time: a request made without a line strobe shows whether the commit is held back, and a lone system strobe in remote mode shows whether the line output really ignores it. A mid-run reset then checks that the outputs return to their quiet state.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        LBK_NORMAL  = 3'd0,
        LBK_REMOTE  = 3'd1,
        LBK_LOCAL   = 3'd2,
        LBK_NETWORK = 3'd3,
        LBK_DUAL    = 3'd4
    } lbk_mode_e;

    localparam logic [1:0] PIN_LVL_LOW  = 2'b00;
    localparam logic [1:0] PIN_LVL_MID  = 2'b01;
    localparam logic [1:0] PIN_LVL_HIGH = 2'b10;

    // Line stream is turned back towards the line.
    function automatic logic turns_line(input lbk_mode_e m);
        return (m == LBK_REMOTE) || (m == LBK_NETWORK) || (m == LBK_DUAL);
    endfunction

    // System stream is turned back towards the system.
    function automatic logic turns_sys(input lbk_mode_e m);
        return (m == LBK_LOCAL) || (m == LBK_DUAL);
    endfunction

endpackage

// File: rtl/lbk_req_decode.sv
module lbk_req_decode
    import lbk_pkg::*;
(
    input  logic       ctl_use_pins,
    input  logic       host_rmt_req,
    input  logic       host_loc_req,
    input  logic       host_net_det_en,
    input  logic [1:0] pin_rmt_lvl,
    input  logic       pin_loc_req,
    input  logic       net_pat_seen,
    output lbk_mode_e  req_mode
);

    logic rmt_want;
    logic loc_want;
    logic det_en;
    logic net_live;

    always_comb begin
        if (ctl_use_pins) begin
            rmt_want = (pin_rmt_lvl == PIN_LVL_HIGH);
            det_en   = (pin_rmt_lvl == PIN_LVL_MID);
            loc_want = pin_loc_req;
        end else begin
            rmt_want = host_rmt_req;
            det_en   = host_net_det_en;
            loc_want = host_loc_req;
        end

        // A remote request overrides network loopback.
        net_live = det_en && net_pat_seen && !rmt_want;

        if ((rmt_want || net_live) && loc_want) begin
            req_mode = LBK_DUAL;
        end else if (rmt_want) begin
            req_mode = LBK_REMOTE;
        end else if (net_live) begin
            req_mode = LBK_NETWORK;
        end else if (loc_want) begin
            req_mode = LBK_LOCAL;
        end else begin
            req_mode = LBK_NORMAL;
        end
    end

endmodule

// File: rtl/lbk_bit_path.sv
module lbk_bit_path #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_alt,
    input  logic [DW-1:0] pri_data,
    input  logic          pri_stb,
    input  logic [DW-1:0] alt_data,
    input  logic          alt_stb,
    output logic [DW-1:0] out_data,
    output logic          out_stb
);

    typedef struct packed {
        logic          stb;
        logic [DW-1:0] data;
    } path_t;

    path_t st_d;
    path_t st_q;

    always_comb begin
        st_d = st_q;
        if (use_alt) begin
            st_d.stb = alt_stb;
            if (alt_stb) st_d.data = alt_data;
        end else begin
            st_d.stb = pri_stb;
            if (pri_stb) st_d.data = pri_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.data;
    assign out_stb  = st_q.stb;

endmodule

// File: rtl/lbk_ctrl.sv
module lbk_ctrl
    import lbk_pkg::*;
#(
    parameter int DW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_use_pins,
    input  logic              host_rmt_req,
    input  logic              host_loc_req,
    input  logic              host_net_det_en,
    input  logic [1:0]        pin_rmt_lvl,
    input  logic              pin_loc_req,
    input  logic              net_pat_seen,
    input  logic [DW-1:0]     sys_tx_data,
    input  logic              sys_tx_stb,
    input  logic [DW-1:0]     line_rx_data,
    input  logic              line_rx_stb,
    output logic [DW-1:0]     line_tx_data,
    output logic              line_tx_stb,
    output logic [DW-1:0]     sys_rx_data,
    output logic              sys_rx_stb,
    output logic [STAT_W-1:0] mode_stat
);

    typedef struct packed {
        lbk_mode_e mode;
    } ctl_t;

    lbk_mode_e req_mode;
    ctl_t      ctl_d;
    ctl_t      ctl_q;

    lbk_req_decode u_decode (
        .ctl_use_pins    (ctl_use_pins),
        .host_rmt_req    (host_rmt_req),
        .host_loc_req    (host_loc_req),
        .host_net_det_en (host_net_det_en),
        .pin_rmt_lvl     (pin_rmt_lvl),
        .pin_loc_req     (pin_loc_req),
        .net_pat_seen    (net_pat_seen),
        .req_mode        (req_mode)
    );

    // The new mode is adopted only on a line bit boundary, and the path
    // registers see it in the same cycle, so routing and status move together.
    always_comb begin
        ctl_d = ctl_q;
        if (line_rx_stb) ctl_d.mode = req_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode <= LBK_NORMAL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lbk_bit_path #(.DW(DW)) u_to_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_alt  (turns_line(ctl_d.mode)),
        .pri_data (sys_tx_data),
        .pri_stb  (sys_tx_stb),
        .alt_data (line_rx_data),
        .alt_stb  (line_rx_stb),
        .out_data (line_tx_data),
        .out_stb  (line_tx_stb)
    );

    lbk_bit_path #(.DW(DW)) u_to_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_alt  (turns_sys(ctl_d.mode)),
        .pri_data (line_rx_data),
        .pri_stb  (line_rx_stb),
        .alt_data (sys_tx_data),
        .alt_stb  (sys_tx_stb),
        .out_data (sys_rx_data),
        .out_stb  (sys_rx_stb)
    );

    assign mode_stat = ctl_q.mode;

endmodule

// File: rtl/lbk_ctrl_chk.sv
module lbk_ctrl_chk #(
    parameter int DW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] sys_tx_data,
    input logic          sys_tx_stb,
    input logic [DW-1:0] line_rx_data,
    input logic          line_rx_stb,
    input logic [DW-1:0] line_tx_data,
    input logic          line_tx_stb,
    input logic [DW-1:0] sys_rx_data,
    input logic          sys_rx_stb,
    input logic [2:0]    mode_stat
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_STAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_stat <= 3'd4);  // R1

    AST_MODE_ON_LINE_STB: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (mode_stat != $past(mode_stat)) |-> $past(line_rx_stb));  // R9

    AST_LTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !line_tx_stb |-> $stable(line_tx_data));  // R10

    AST_SRX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !sys_rx_stb |-> $stable(sys_rx_data));  // R10

    AST_NORMAL_LTX: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (mode_stat == 3'd0) |-> (line_tx_stb == $past(sys_tx_stb)));  // R2

    AST_TURN_LINE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (mode_stat == 3'd1 || mode_stat == 3'd3 || mode_stat == 3'd4)
        |-> (line_tx_stb == $past(line_rx_stb)));  // R3

    AST_NET_LIKE_RMT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (mode_stat == 3'd3) |-> (sys_rx_stb == $past(line_rx_stb)));  // R5

    AST_TURN_SYS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (mode_stat == 3'd2 || mode_stat == 3'd4)
        |-> (sys_rx_stb == $past(sys_tx_stb)));  // R6

endmodule

bind lbk_ctrl lbk_ctrl_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_tx_data  (sys_tx_data),
    .sys_tx_stb   (sys_tx_stb),
    .line_rx_data (line_rx_data),
    .line_rx_stb  (line_rx_stb),
    .line_tx_data (line_tx_data),
    .line_tx_stb  (line_tx_stb),
    .sys_rx_data  (sys_rx_data),
    .sys_rx_stb   (sys_rx_stb),
    .mode_stat    (mode_stat)
);

// File: tb/lbk_ctrl_tb.sv
module lbk_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_use_pins;
    logic       host_rmt_req, host_loc_req, host_net_det_en;
    logic [1:0] pin_rmt_lvl;
    logic       pin_loc_req, net_pat_seen;
    logic [0:0] sys_tx_data, line_rx_data, line_tx_data, sys_rx_data;
    logic       sys_tx_stb, line_rx_stb, line_tx_stb, sys_rx_stb;
    logic [2:0] mode_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lbk_ctrl u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_use_pins    (ctl_use_pins),
        .host_rmt_req    (host_rmt_req),
        .host_loc_req    (host_loc_req),
        .host_net_det_en (host_net_det_en),
        .pin_rmt_lvl     (pin_rmt_lvl),
        .pin_loc_req     (pin_loc_req),
        .net_pat_seen    (net_pat_seen),
        .sys_tx_data     (sys_tx_data),
        .sys_tx_stb      (sys_tx_stb),
        .line_rx_data    (line_rx_data),
        .line_rx_stb     (line_rx_stb),
        .line_tx_data    (line_tx_data),
        .line_tx_stb     (line_tx_stb),
        .sys_rx_data     (sys_rx_data),
        .sys_rx_stb      (sys_rx_stb),
        .mode_stat       (mode_stat)
    );

    // Fields: [14]pins [13]rmt [12]loc [11]det [10:9]pin lvl [8]pin loc
    // [7]flag [6]sys data [5]line data [4:2]mode [1]line tx data [0]sys rx data
    localparam int NV = 22;
    localparam logic [14:0] VEC [NV] = '{
        15'b0_000_00_0_0_1_0_000_1_0,  // R2 normal
        15'b0_000_00_0_0_0_1_000_0_1,  // R2 normal, swapped data
        15'b0_100_00_0_0_1_0_001_0_0,  // R3 remote
        15'b0_100_00_0_0_0_1_001_1_1,  // R3 remote, swapped data
        15'b0_010_00_0_0_1_0_010_1_1,  // R4 local
        15'b0_010_00_0_0_0_1_010_0_0,  // R4 local, swapped data
        15'b0_110_00_0_0_1_0_100_0_1,  // R6 dual from remote+local
        15'b0_110_00_0_0_0_1_100_1_0,  // R6 dual, swapped data
        15'b0_001_00_0_0_1_0_000_1_0,  // R5 detect on, no flag
        15'b0_001_00_0_1_1_0_011_0_0,  // R5 network
        15'b0_000_00_0_1_1_0_000_1_0,  // R5 flag without enable
        15'b0_011_00_0_1_1_0_100_0_1,  // R6 dual from network+local
        15'b0_101_00_0_1_1_0_001_0_0,  // R5 remote beats network
        15'b1_110_00_0_0_1_0_000_1_0,  // R7 host bits ignored
        15'b1_000_10_0_0_1_0_001_0_0,  // R7 pin high remote
        15'b1_000_10_1_0_1_0_100_0_1,  // R7 pins dual
        15'b1_000_00_1_0_1_0_010_1_1,  // R7 pin local
        15'b1_000_01_0_0_1_0_000_1_0,  // R7 mid, no flag
        15'b1_000_01_0_1_1_0_011_0_0,  // R7 mid + flag network
        15'b1_000_01_1_1_1_0_100_0_1,  // R7 mid + flag + local dual
        15'b1_000_11_0_1_1_0_000_1_0,  // R7 code 11 is low
        15'b0_000_10_1_1_1_0_000_1_0   // R8 pins ignored
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        {ctl_use_pins, host_rmt_req, host_loc_req, host_net_det_en} = '0;
        pin_rmt_lvl = 2'b00; pin_loc_req = 1'b0; net_pat_seen = 1'b0;
        sys_tx_data = '0; sys_tx_stb = 1'b0; line_rx_data = '0; line_rx_stb = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mode", mode_stat, 0);
        check("R1 ltx", {line_tx_stb, line_tx_data}, 0);
        check("R1 srx", {sys_rx_stb, sys_rx_data}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ctl_use_pins    = VEC[i][14];
            host_rmt_req    = VEC[i][13];
            host_loc_req    = VEC[i][12];
            host_net_det_en = VEC[i][11];
            pin_rmt_lvl     = VEC[i][10:9];
            pin_loc_req     = VEC[i][8];
            net_pat_seen    = VEC[i][7];
            sys_tx_data     = VEC[i][6];
            line_rx_data    = VEC[i][5];
            sys_tx_stb      = 1'b1;
            line_rx_stb     = 1'b1;
            @(negedge clk);
            check($sformatf("R2-R8 vec%0d mode", i), mode_stat, VEC[i][4:2]);
            check($sformatf("R2-R8 vec%0d ltx", i), line_tx_data, VEC[i][1]);
            check($sformatf("R2-R8 vec%0d srx", i), sys_rx_data, VEC[i][0]);
            check($sformatf("R2-R8 vec%0d stb", i), {line_tx_stb, sys_rx_stb}, 3);
        end

        // R9: remote requested, no line strobe: stays normal
        ctl_use_pins = 1'b0; host_rmt_req = 1'b1; host_loc_req = 1'b0;
        host_net_det_en = 1'b0; net_pat_seen = 1'b0;
        sys_tx_stb = 1'b1; sys_tx_data = 1'b0; line_rx_stb = 1'b0; line_rx_data = 1'b1;
        @(negedge clk);
        check("R9 held mode", mode_stat, 0);
        check("R9 held routing ltx", {line_tx_stb, line_tx_data}, 2);
        check("R10 srx held", {sys_rx_stb, sys_rx_data}, 0);

        // R9: line strobe commits remote
        sys_tx_stb = 1'b0; sys_tx_data = 1'b1; line_rx_stb = 1'b1; line_rx_data = 1'b1;
        @(negedge clk);
        check("R9 commit mode", mode_stat, 1);
        check("R3 ltx from line", {line_tx_stb, line_tx_data}, 3);
        check("R3 srx from line", {sys_rx_stb, sys_rx_data}, 3);

        // R3: lone system strobe in remote has no effect on line output
        sys_tx_stb = 1'b1; sys_tx_data = 1'b0; line_rx_stb = 1'b0; line_rx_data = 1'b0;
        @(negedge clk);
        check("R3 sys ignored", {line_tx_stb, line_tx_data}, 1);
        check("R10 srx hold", {sys_rx_stb, sys_rx_data}, 1);

        // R10: no strobes, data moving, outputs hold
        sys_tx_stb = 1'b0; line_rx_data = 1'b0;
        @(negedge clk);
        check("R10 ltx hold", {line_tx_stb, line_tx_data}, 1);
        check("R9 mode kept", mode_stat, 1);

        // R1: reset mid-run
        rst_n = 1'b0;
        #1;
        check("R1 midrun mode", mode_stat, 0);
        check("R1 midrun outs", {line_tx_stb, line_tx_data, sys_rx_stb, sys_rx_data}, 0);
        @(negedge clk);
        finish_run();
    end

endmodule